// File: doc/BRIEF.md
# Configurable 32-Source Interrupt Controller

This block gathers up to 32 interrupt lines and reduces them to two requests for a processor: one critical and one non-critical. Software sets up each line through a small register bus at fixed byte addresses. For each line it picks an active sense (high or low, rising or falling), level or edge detection, whether the line is enabled, and which of the two request classes it drives.

Detected events are latched in a status register. Software clears status bits by writing 1 to them. The status register ANDed with the enable register gives a masked status, and only masked bits raise a request. For the critical class the block also forms a vector: a programmable base plus 512 times the number of the lowest-numbered pending critical source. A handler can use this value directly as a jump target.

The interrupt inputs are taken to be synchronous to `clk`. Register reads are combinational from the address. A write takes effect at the rising clock edge where `bus_wr` is high.

Top module: `irq_ctl`

## Requirements
- R1: After an asynchronous reset (rst_n low), the status, enable, critical, trigger and vector-base registers read 0, the polarity register reads all ones, and both requests are low.
- R2: Register byte addresses are 0xC0 status, 0xC2 enable, 0xC3 critical-class, 0xC4 polarity, 0xC5 trigger, 0xC6 masked status, 0xC7 vector and 0xC8 vector base. Bit i of each per-source register belongs to source i. Any other address reads 0.
- R3: A source with trigger bit 0 is level sensed, active high when its polarity bit is 1 and active low when 0. Each clock edge at which the input is at its active level sets the status bit, so the bit reads 1 from the next cycle on.
- R4: A source with trigger bit 1 is edge sensed. With polarity 1 a 0-to-1 change between two consecutive sampled values sets the status bit. With polarity 0 a 1-to-0 change does. A steady input never sets it again.
- R5: Writing 1 to a status bit at 0xC0 clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over the clear, so a level source that is still active keeps its bit set.
- R6: The masked status at 0xC6 equals status AND enable. While no source is enabled, both requests stay low.
- R7: crit_req is high when any masked bit has its critical-class bit at 1. noncrit_req is high when any masked bit has its critical-class bit at 0. Both are combinational from the registers.
- R8: The vector at 0xC7 reads base + 512 × n (modulo 2^32), where n is the lowest-numbered source that is masked and critical. With no such source it reads the base.
- R9: Writes to 0xC6, 0xC7 or an unmapped address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NSRC | Interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| crit_req | output | 1 | Critical-class request |
| noncrit_req | output | 1 | Non-critical-class request |

## Verification
The assertions check on every cycle that each detected event sets its status bit at the next edge and that no status bit rises without one. They also check that a write-1 clear takes effect when no event competes with it, that both requests stay silent while everything is disabled, and that the vector equals the base whenever no critical request is pending. The priority picker is checked to always name a pending source with no lower-numbered candidate. Only the bench scenarios can show the exact polarity and edge behaviour of particular lines, the register decode, the vector arithmetic for specific sources and bases, and that writes to read-only or unmapped addresses are ignored. For that the bench compares against its reference model every cycle and adds directed readbacks.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int DATA_W    = 32;
  localparam int VEC_SHIFT = 9;

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [7:0]        addr_t;

  localparam addr_t A_STATUS = 8'hC0;
  localparam addr_t A_ENABLE = 8'hC2;
  localparam addr_t A_CRIT   = 8'hC3;
  localparam addr_t A_POL    = 8'hC4;
  localparam addr_t A_TRIG   = 8'hC5;
  localparam addr_t A_MASKED = 8'hC6;
  localparam addr_t A_VECTOR = 8'hC7;
  localparam addr_t A_VBASE  = 8'hC8;

  // Vector for source number n: base plus n steps of 2^VEC_SHIFT.
  function automatic word_t vec_value(input word_t base, input word_t n);
    return base + (n << VEC_SHIFT);
  endfunction
endpackage

// File: rtl/irq_ctl_detect.sv
module irq_ctl_detect #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] trig,
  output logic [N-1:0] evt
);
  logic [N-1:0] prev;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic active;
    logic edge_hit;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev[g] <= 1'b0;
      else        prev[g] <= src[g];
    end

    assign active   = pol[g] ? src[g] : ~src[g];
    assign edge_hit = pol[g] ? (src[g] & ~prev[g]) : (~src[g] & prev[g]);
    assign evt[g]   = trig[g] ? edge_hit : active;
  end

  // Edge mode with a steady input gives no event (R4)
  p_edge_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((src[0] == prev[0]) && trig[0]) |-> !evt[0]);
endmodule

// File: rtl/irq_ctl_pick.sv
module irq_ctl_pick #(
  parameter int N    = 32,
  parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    cand,
  output logic            found,
  output logic [IDXW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDXW'(i);
      end
    end
  end

  logic [N-1:0] below;
  assign below = (N'(1) << idx) - N'(1);

  // The chosen source is pending and nothing lower-numbered is (R8)
  p_pick_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (cand[idx] && ((cand & below) == '0)));
  p_pick_none_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !found);
endmodule

// File: rtl/irq_ctl.sv
module irq_ctl
  import irq_ctl_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_in,
  input  logic            bus_wr,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  output logic            crit_req,
  output logic            noncrit_req
);
  localparam int IDXW = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] stat, en, crit, pol, trig;
  word_t           vbase;
  logic [NSRC-1:0] evt, clr, masked;
  logic            found;
  logic [IDXW-1:0] idx;
  word_t           vec;
  logic [NSRC-1:0] wbits;

  assign wbits = bus_wdata[NSRC-1:0];

  irq_ctl_detect #(.N(NSRC)) u_detect (
    .clk(clk), .rst_n(rst_n), .src(irq_in), .pol(pol), .trig(trig), .evt(evt)
  );

  assign clr = (bus_wr && bus_addr == A_STATUS) ? wbits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= '0;
      en    <= '0;
      crit  <= '0;
      pol   <= '1;
      trig  <= '0;
      vbase <= '0;
    end else begin
      stat <= (stat & ~clr) | evt;
      if (bus_wr) begin
        case (bus_addr)
          A_ENABLE: en    <= wbits;
          A_CRIT:   crit  <= wbits;
          A_POL:    pol   <= wbits;
          A_TRIG:   trig  <= wbits;
          A_VBASE:  vbase <= bus_wdata;
          default:  ;
        endcase
      end
    end
  end

  assign masked      = stat & en;
  assign crit_req    = |(masked & crit);
  assign noncrit_req = |(masked & ~crit);

  irq_ctl_pick #(.N(NSRC), .IDXW(IDXW)) u_pick (
    .clk(clk), .rst_n(rst_n), .cand(masked & crit), .found(found), .idx(idx)
  );

  assign vec = found ? vec_value(vbase, word_t'(idx)) : vbase;

  always_comb begin
    case (bus_addr)
      A_STATUS: bus_rdata = word_t'(stat);
      A_ENABLE: bus_rdata = word_t'(en);
      A_CRIT:   bus_rdata = word_t'(crit);
      A_POL:    bus_rdata = word_t'(pol);
      A_TRIG:   bus_rdata = word_t'(trig);
      A_MASKED: bus_rdata = word_t'(masked);
      A_VECTOR: bus_rdata = vec;
      A_VBASE:  bus_rdata = vbase;
      default:  bus_rdata = '0;
    endcase
  end

  // Every detected event is latched at the next edge (R3)
  p_event_latched_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));
  // No status bit rises without an event (R5)
  p_rise_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & ~$past(stat) & ~$past(evt)) == '0));
  // A write-1 clear with no competing event empties the bit (R5)
  p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_STATUS) |=> ((stat & $past(wbits & ~evt)) == '0));
  // Nothing enabled means no request (R6)
  p_quiet_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> (!crit_req && !noncrit_req));
  // Vector falls back to the base with no critical request (R8)
  p_vec_base_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !crit_req |-> (vec == vbase));
endmodule

// File: tb/irq_ctl_tb.sv
`timescale 1ns/1ps
module irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        creq, nreq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(src), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .crit_req(creq), .noncrit_req(nreq)
  );

  // Behavioural reference model
  bit [31:0] m_stat, m_en, m_crit, m_pol, m_trig, m_vb, m_prev;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_en = 0; m_crit = 0; m_pol = 32'hFFFF_FFFF;
      m_trig = 0; m_vb = 0; m_prev = 0;
    end else begin
      bit [31:0] nstat;
      nstat = m_stat;
      for (int k = 0; k < 32; k++) begin
        bit hit;
        if (m_trig[k]) begin
          if (m_pol[k]) hit = (src[k] == 1) && (m_prev[k] == 0);
          else          hit = (src[k] == 0) && (m_prev[k] == 1);
        end else begin
          hit = (src[k] == m_pol[k]);
        end
        if (wr && addr == 8'hC0 && wdata[k]) nstat[k] = 0;
        if (hit) nstat[k] = 1;
      end
      m_stat = nstat;
      m_prev = src;
      if (wr) begin
        if (addr == 8'hC2) m_en = wdata;
        if (addr == 8'hC3) m_crit = wdata;
        if (addr == 8'hC4) m_pol = wdata;
        if (addr == 8'hC5) m_trig = wdata;
        if (addr == 8'hC8) m_vb = wdata;
      end
    end
  end

  function automatic bit [31:0] m_vec();
    bit [31:0] v;
    v = m_vb;
    for (int k = 31; k >= 0; k--)
      if (m_stat[k] && m_en[k] && m_crit[k]) v = m_vb + k * 512;
    return v;
  endfunction

  function automatic bit [31:0] m_read(input bit [7:0] a);
    if (a == 8'hC0) return m_stat;
    if (a == 8'hC2) return m_en;
    if (a == 8'hC3) return m_crit;
    if (a == 8'hC4) return m_pol;
    if (a == 8'hC5) return m_trig;
    if (a == 8'hC6) return m_stat & m_en;
    if (a == 8'hC7) return m_vec();
    if (a == 8'hC8) return m_vb;
    return 0;
  endfunction

  function automatic string tag_of(input bit [7:0] a);
    if (a == 8'hC0) return "R5";
    if (a == 8'hC6) return "R6";
    if (a == 8'hC7) return "R8";
    return "R2";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 crit_req", {31'b0, creq}, {31'b0, |(m_stat & m_en & m_crit)});
      check("R7 noncrit_req", {31'b0, nreq}, {31'b0, |(m_stat & m_en & ~m_crit)});
      check(tag_of(addr), rdata, m_read(addr));
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk); #1;
    addr = a;
    @(negedge clk);
    check(tag, rdata, exp);
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk); #1;
    src = v;
  endtask

  task automatic run_seq();
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd_check("R1 polarity", 8'hC4, 32'hFFFF_FFFF);
    rd_check("R1 status", 8'hC0, 32'h0);
    rd_check("R1 vbase", 8'hC8, 32'h0);
    check("R1 requests", {30'b0, creq, nreq}, 32'h0);
    // R2 register programming and readback
    bus_write(8'hC3, 32'h0000_0024);
    rd_check("R2 critical", 8'hC3, 32'h0000_0024);
    bus_write(8'hC5, 32'h0000_00A4);
    rd_check("R2 trigger", 8'hC5, 32'h0000_00A4);
    bus_write(8'hC8, 32'h0001_0000);
    rd_check("R2 vbase", 8'hC8, 32'h0001_0000);
    // R3 level source 3, not yet enabled
    set_src(32'h0000_0008);
    rd_check("R3 level status", 8'hC0, 32'h0000_0008);
    rd_check("R6 masked disabled", 8'hC6, 32'h0);
    // R6/R7 enable all
    bus_write(8'hC2, 32'hFFFF_FFFF);
    rd_check("R6 masked", 8'hC6, 32'h0000_0008);
    check("R7 noncrit only", {30'b0, creq, nreq}, 32'h1);
    // R5 clear while level still active
    bus_write(8'hC0, 32'h0000_0008);
    rd_check("R5 level re-set", 8'hC0, 32'h0000_0008);
    set_src(32'h0);
    bus_write(8'hC0, 32'h0000_0008);
    rd_check("R5 cleared", 8'hC0, 32'h0);
    check("R7 idle", {30'b0, creq, nreq}, 32'h0);
    // R4 rising edge on critical source 5, R8 vector
    set_src(32'h0000_0020);
    rd_check("R4 rising", 8'hC0, 32'h0000_0020);
    check("R7 crit", {30'b0, creq, nreq}, 32'h2);
    rd_check("R8 vector src5", 8'hC7, 32'h0001_0A00);
    bus_write(8'hC0, 32'h0000_0020);
    rd_check("R4 steady no re-set", 8'hC0, 32'h0);
    // R8 priority: sources 2 and 5 together
    set_src(32'h0);
    set_src(32'h0000_0024);
    rd_check("R8 status both", 8'hC0, 32'h0000_0024);
    rd_check("R8 lowest wins", 8'hC7, 32'h0001_0400);
    bus_write(8'hC0, 32'h0000_0024);
    rd_check("R8 base idle", 8'hC7, 32'h0001_0000);
    // R4 falling edge on source 7
    set_src(32'h0000_00A4);
    bus_write(8'hC0, 32'hFFFF_FFFF);
    bus_write(8'hC4, 32'hFFFF_FF7F);
    set_src(32'h0000_0024);
    rd_check("R4 falling", 8'hC0, 32'h0000_0080);
    check("R7 noncrit src7", {30'b0, creq, nreq}, 32'h1);
    // R9 writes to read-only and unmapped addresses
    bus_write(8'hC6, 32'h0);
    bus_write(8'hC7, 32'h1234_5678);
    bus_write(8'hC1, 32'hFFFF_FFFF);
    rd_check("R9 masked kept", 8'hC6, 32'h0000_0080);
    rd_check("R9 vbase kept", 8'hC8, 32'h0001_0000);
    rd_check("R9 unmapped", 8'hC1, 32'h0);
    // R8 wrap of vector arithmetic
    bus_write(8'hC0, 32'hFFFF_FFFF);
    bus_write(8'hC8, 32'hFFFF_FF00);
    bus_write(8'hC3, 32'h8000_0000);
    bus_write(8'hC5, 32'h0);
    bus_write(8'hC4, 32'hFFFF_FFFF);
    set_src(32'h8000_0000);
    rd_check("R8 wrap", 8'hC7, 32'h0000_3D00);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    fork
      run_seq();
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule